// File: doc/BRIEF.md
# Gray-Scale PWM Segment Driver

This block turns a packed display memory into pulse-width-modulated segment enables for a panel of 64 segments and 16 commons. Every pixel carries a 2-bit code. The code picks one of four width registers that the host programs, and that width sets how many sections of the active window the segment stays on. The block scans the commons one after another. For each common it first fetches one memory word per segment through a synchronous read port. It then runs a window of sections, during which the common strobe is high and every segment enable reflects its pixel's width.

Two frame modes set the length of the window. The slow mode has a long window and the fast mode has a short one. A width above the window's last section index is held at that index. The display-enable input blanks every output. While the display is disabled the scan waits at its starting point, so each enable begins cleanly with the first common.

Top module: `gsPwmSegDriver`

## Requirements
- R1: After reset, segOn and comOn are all zero, every width register holds 0, and the frame mode is slow (24-section window).
- R2: While fetching for common c, the block reads memory word segment*8 + c/2 (memory data returned one cycle after the address). Bits 3:2 of the word are the code for an even c, and bits 1:0 are the code for an odd c.
- R3: Code 11 uses the width loaded with wLevel=0, code 10 uses wLevel=1, code 01 uses wLevel=2, and code 00 uses wLevel=3.
- R4: In section k (counted from 0) of a window, segOn[s] is 1 exactly when k is below the clamped width of pixel s. A width of 0 keeps the segment off for the whole window, and within a window a segment never turns on again after it has turned off.
- R5: In slow mode (modeFastIn=0 at a modeLoad) a window lasts 24 consecutive cycles, and any width above 23 acts as 23.
- R6: In fast mode (modeFastIn=1 at a modeLoad) a window lasts 13 consecutive cycles, and any width above 12 acts as 12.
- R7: Commons are scanned in the order 0,1,...,15,0,... and comOn is one-hot with bit c high for the whole window of common c. Between windows there are exactly 65 cycles in which all outputs are zero.
- R8: While dispOn is 0, segOn and comOn are zero from the next clock edge onward. After dispOn returns to 1, scanning restarts with common 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispOn | input | 1 | Display enable; 0 blanks the outputs and parks the scan |
| modeLoad | input | 1 | Load strobe for the frame mode |
| modeFastIn | input | 1 | Frame mode to load: 1 fast, 0 slow |
| wLoad | input | 1 | Load strobe for a width register |
| wLevel | input | 2 | Width register selected by wLoad |
| wValue | input | 5 | Width value to load |
| memAddr | output | 9 | Display memory read address |
| memData | input | 4 | Display memory read data, one cycle after the address |
| segOn | output | 64 | Per-segment ON enable |
| comOn | output | 16 | One-hot common strobe |

## Verification
The sharpest coincidence is the capture of the last segment's code and the first section compare. The code for segment 63 is written in the cycle just before section 0 reads it. The bench fills memory so that segment 63's code differs between neighbouring commons, and it compares segOn[63] in section 0 against its own model. A second coincidence is clamping and the window end: widths at or above the limit put the fall of a segment on the last section. A scoreboard checks that this fall and the falling common strobe line up, and it also checks the exact gap length.

// File: rtl/gsPwmPkg.sv
package gsPwmPkg;
  localparam int NSEG      = 64;
  localparam int NCOM      = 16;
  localparam int WIDTH_W   = 5;
  localparam int SLOW_SECT = 24;
  localparam int FAST_SECT = 13;
  localparam int NLVL      = 4;
  localparam int SEG_W     = $clog2(NSEG);
  localparam int COM_W     = $clog2(NCOM);
  localparam int SECT_W    = $clog2(SLOW_SECT);
  localparam int ADDR_W    = SEG_W + COM_W - 1;

  typedef struct packed {
    logic              capValid;
    logic [SEG_W-1:0]  capSeg;
    logic              oddCom;
    logic              scan;
    logic [SECT_W-1:0] sect;
    logic [COM_W-1:0]  com;
    logic              fast;
  } gsStrobe_t;
endpackage

// File: rtl/gsScanCtrl.sv
module gsScanCtrl
  import gsPwmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispOn,
  input  logic              modeLoad,
  input  logic              modeFastIn,
  output logic [ADDR_W-1:0] memAddr,
  output gsStrobe_t         strb
);
  typedef enum logic {ST_FETCH, ST_SCAN} state_t;

  state_t            state;
  logic [SEG_W:0]    segIdx;
  logic [COM_W-1:0]  com;
  logic [SECT_W-1:0] sect;
  logic              fast;
  logic              capValid;
  logic [SEG_W-1:0]  capSeg;
  logic              issue;
  logic [SECT_W-1:0] lastSect;

  assign lastSect = fast ? SECT_W'(FAST_SECT - 1) : SECT_W'(SLOW_SECT - 1);
  assign issue    = dispOn && (state == ST_FETCH) && (segIdx < (SEG_W+1)'(NSEG));
  assign memAddr  = {segIdx[SEG_W-1:0], com[COM_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_FETCH;
      segIdx   <= '0;
      com      <= '0;
      sect     <= '0;
      fast     <= 1'b0;
      capValid <= 1'b0;
      capSeg   <= '0;
    end else begin
      if (modeLoad) fast <= modeFastIn;
      capValid <= issue;
      capSeg   <= segIdx[SEG_W-1:0];
      if (!dispOn) begin
        state  <= ST_FETCH;
        segIdx <= '0;
        com    <= '0;
        sect   <= '0;
      end else begin
        case (state)
          ST_FETCH: begin
            if (segIdx == (SEG_W+1)'(NSEG)) begin
              state  <= ST_SCAN;
              segIdx <= '0;
              sect   <= '0;
            end else begin
              segIdx <= segIdx + (SEG_W+1)'(1);
            end
          end
          ST_SCAN: begin
            if (sect >= lastSect) begin
              state <= ST_FETCH;
              sect  <= '0;
              com   <= (com == COM_W'(NCOM - 1)) ? '0 : com + COM_W'(1);
            end else begin
              sect <= sect + SECT_W'(1);
            end
          end
          default: state <= ST_FETCH;
        endcase
      end
    end
  end

  always_comb begin
    strb.capValid = capValid;
    strb.capSeg   = capSeg;
    strb.oddCom   = com[0];
    strb.scan     = (state == ST_SCAN);
    strb.sect     = sect;
    strb.com      = com;
    strb.fast     = fast;
  end
endmodule

// File: rtl/gsSegPath.sv
module gsSegPath
  import gsPwmPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               dispOn,
  input  logic               wLoad,
  input  logic [1:0]         wLevel,
  input  logic [WIDTH_W-1:0] wValue,
  input  logic [3:0]         memData,
  input  gsStrobe_t          strb,
  output logic [NSEG-1:0]    segOn,
  output logic [NCOM-1:0]    comOn
);
  logic [WIDTH_W-1:0] lvlW   [NLVL];
  logic [WIDTH_W-1:0] lvlEff [NLVL];
  logic [1:0]         code   [NSEG];
  logic [NSEG-1:0]    segNext;
  logic [WIDTH_W-1:0] maxW;

  assign maxW = strb.fast ? WIDTH_W'(FAST_SECT - 1) : WIDTH_W'(SLOW_SECT - 1);

  // width table, loaded by the host at any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NLVL; l++) lvlW[l] <= '0;
    end else if (wLoad) begin
      lvlW[wLevel] <= wValue;
    end
  end

  // per-segment code capture: even common takes the upper pair
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSEG; s++) code[s] <= '0;
    end else if (strb.capValid) begin
      code[strb.capSeg] <= strb.oddCom ? memData[1:0] : memData[3:2];
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_clamp
    assign lvlEff[l] = (lvlW[l] > maxW) ? maxW : lvlW[l];
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [1:0] lvlIdx;
    assign lvlIdx     = ~code[s];  // 11 -> level 0 ... 00 -> level 3
    assign segNext[s] = int'(strb.sect) < int'(lvlEff[lvlIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segOn <= '0;
      comOn <= '0;
    end else if (strb.scan && dispOn) begin
      segOn <= segNext;
      comOn <= NCOM'(1) << strb.com;
    end else begin
      segOn <= '0;
      comOn <= '0;
    end
  end
endmodule

// File: rtl/gsPwmSegDriver.sv
module gsPwmSegDriver
  import gsPwmPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               dispOn,
  input  logic               modeLoad,
  input  logic               modeFastIn,
  input  logic               wLoad,
  input  logic [1:0]         wLevel,
  input  logic [WIDTH_W-1:0] wValue,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [3:0]         memData,
  output logic [NSEG-1:0]    segOn,
  output logic [NCOM-1:0]    comOn
);
  gsStrobe_t strb;

  gsScanCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .dispOn(dispOn),
    .modeLoad(modeLoad), .modeFastIn(modeFastIn),
    .memAddr(memAddr), .strb(strb)
  );

  gsSegPath path_i (
    .clk(clk), .rstN(rstN), .dispOn(dispOn),
    .wLoad(wLoad), .wLevel(wLevel), .wValue(wValue),
    .memData(memData), .strb(strb),
    .segOn(segOn), .comOn(comOn)
  );
endmodule

// File: rtl/gsPwmSegDriverChk.sv
module gsPwmSegDriverChk
  import gsPwmPkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            dispOn,
  input logic [NSEG-1:0] segOn,
  input logic [NCOM-1:0] comOn
);
  localparam int RUN_W = $clog2(SLOW_SECT) + 1;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)       runLen <= '0;
    else if (|comOn) runLen <= runLen + RUN_W'(1);
    else             runLen <= '0;
  end

  p_onehot_com_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comOn));

  p_com_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((|comOn) && (|$past(comOn))) |-> (comOn == $past(comOn)));

  p_seg_needs_com_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|segOn) |-> (|comOn));

  p_no_rerise_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|comOn) && (|$past(comOn))) |-> ((segOn & ~$past(segOn)) == '0));

  p_window_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|comOn) |-> (runLen < RUN_W'(SLOW_SECT)));

  p_off_blank_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dispOn |=> ((comOn == '0) && (segOn == '0)));
endmodule

bind gsPwmSegDriver gsPwmSegDriverChk chk_i (
  .clk(clk), .rstN(rstN), .dispOn(dispOn), .segOn(segOn), .comOn(comOn)
);

// File: tb/gsPwmSegDriver_tb_top.sv
module gsPwmSegDriver_tb_top;
  import gsPwmPkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               dispOn = 1'b0;
  logic               modeLoad = 1'b0;
  logic               modeFastIn = 1'b0;
  logic               wLoad = 1'b0;
  logic [1:0]         wLevel = '0;
  logic [WIDTH_W-1:0] wValue = '0;
  logic [ADDR_W-1:0]  memAddr;
  logic [3:0]         memData = '0;
  logic [NSEG-1:0]    segOn;
  logic [NCOM-1:0]    comOn;

  always #5 clk = ~clk;

  gsPwmSegDriver dut_i (
    .clk(clk), .rstN(rstN), .dispOn(dispOn), .modeLoad(modeLoad),
    .modeFastIn(modeFastIn), .wLoad(wLoad), .wLevel(wLevel), .wValue(wValue),
    .memAddr(memAddr), .memData(memData), .segOn(segOn), .comOn(comOn)
  );

  logic [3:0] mem [NSEG*NCOM/2];
  always @(posedge clk) memData <= mem[memAddr];

  typedef struct {
    int              com;
    int              sect;
    logic [NSEG-1:0] vec;
  } expItem_t;
  expItem_t q[$];

  int  nChecks = 0;
  int  nFails  = 0;
  int  mW[NLVL] = '{0, 0, 0, 0};
  bit  mFast = 1'b0;
  int  runLen = 0;
  int  lastLen = 0;
  int  gap = 0;
  bit  gapValid = 1'b0;
  bit  prevOn = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < NSEG*NCOM/2; i++)
      mem[i] = 4'((i * seed + i / 5 + seed * 3 + (i >> 3) * 7) % 16);
  endtask

  task automatic loadW(input int lvl, input int val);
    @(negedge clk);
    wLoad = 1'b1; wLevel = 2'(lvl); wValue = WIDTH_W'(val);
    @(negedge clk);
    wLoad = 1'b0;
    mW[lvl] = val;
  endtask

  task automatic setMode(input bit f);
    @(negedge clk);
    modeLoad = 1'b1; modeFastIn = f;
    @(negedge clk);
    modeLoad = 1'b0;
    mFast = f;
  endtask

  // driver: queue the expected windows, enable, wait until all consumed
  task automatic runScene(input int nWin);
    int n;
    n = mFast ? FAST_SECT : SLOW_SECT;
    for (int w = 0; w < nWin; w++) begin
      for (int k = 0; k < n; k++) begin
        expItem_t it;
        it.com = w % NCOM;
        it.sect = k;
        for (int s = 0; s < NSEG; s++) begin
          logic [3:0] word;
          logic [1:0] cd;
          int wc;
          word = mem[s * (NCOM/2) + it.com / 2];
          cd = (it.com % 2 == 1) ? word[1:0] : word[3:2];
          wc = mW[3 - int'(cd)];
          if (wc > n - 1) wc = n - 1;
          it.vec[s] = (k < wc);
        end
        q.push_back(it);
      end
    end
    @(negedge clk);
    dispOn = 1'b1;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    dispOn = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check((segOn == '0) && (comOn == '0), "R8 blank while disabled",
            {segOn}, 64'h0);
    end
  endtask

  // monitor: compare every active section against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (!dispOn) begin
        gapValid = 1'b0;
        gap = 0;
      end
      if (comOn != '0) begin
        runLen++;
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected section", 64'(comOn), 64'h0);
        end else begin
          expItem_t it;
          it = q.pop_front();
          check(comOn == (NCOM'(1) << it.com), "R7,R8 common order",
                64'(comOn), 64'(NCOM'(1) << it.com));
          check((it.sect == 0) == !prevOn, mFast ? "R6 window boundary" : "R5 window boundary",
                64'(prevOn), 64'(it.sect != 0));
          check(segOn == it.vec, "R2,R3,R4 segment pattern", segOn, it.vec);
          if (it.sect == 0 && gapValid)
            check(gap == NSEG + 1, "R7 gap length", 64'(gap), 64'(NSEG + 1));
        end
        gap = 0;
      end else begin
        if (prevOn) begin
          lastLen = runLen;
          gapValid = dispOn;
        end
        runLen = 0;
        gap++;
      end
      prevOn = (comOn != '0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    fillMem(5);
    repeat (3) @(negedge clk);
    check((segOn == '0) && (comOn == '0), "R1 outputs during reset", segOn, 64'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check((segOn == '0) && (comOn == '0), "R1 outputs after reset", segOn, 64'h0);

    // slow default; clamp of 31 to 23, width 0 never on
    loadW(0, 5); loadW(1, 23); loadW(2, 31); loadW(3, 0);
    runScene(NCOM + 1);
    check(lastLen == SLOW_SECT, "R1 default slow window", 64'(lastLen), 64'(SLOW_SECT));

    // fast mode, clamp to 12, restart at common 0
    fillMem(11);
    setMode(1'b1);
    loadW(0, 12); loadW(1, 13); loadW(2, 1); loadW(3, 30);
    runScene(NCOM + 1);
    check(lastLen == FAST_SECT, "R6 fast window", 64'(lastLen), 64'(FAST_SECT));

    // back to slow with a width one above the limit
    fillMem(3);
    setMode(1'b0);
    loadW(0, 24); loadW(1, 0); loadW(2, 1); loadW(3, 22);
    runScene(3);
    check(lastLen == SLOW_SECT, "R5 slow window", 64'(lastLen), 64'(SLOW_SECT));

    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule